// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host-side master for a 128-word by 8-bit nonvolatile memory that sits on three wires: a chip-enable line, a shift clock and one bidirectional data line. A one-word request port takes an operation code, a 7-bit word address and an 8-bit write value. The controller serialises the frame while chip enable is high, then lowers chip enable to start the operation. For erase or write it holds the data line at the level that selects the action and gives a separate start pulse. It then waits out the programming time and raises chip enable again. A read clocks the word back out, least significant bit first. For erase-then-write, the frame latched in the memory is used a second time, so no new frame is shifted.

The data line appears as three plain signals: a driven value, an output enable and the sensed input. The pad or a pull-up outside the block resolves the line. Every interval is a parameter counted in system clock cycles: clock high and low times, the spacing between chip-enable and clock edges, data hold after a falling clock edge, read data delay and programming time. Each request ends with a one-cycle done strobe. Read data is presented on that strobe.

Top module: `tw_eeprom_host`

## Requirements
- R1: While rst_n is low at a clock edge the outputs go to mem_ce=1, mem_clk=0, mem_d_oe=0, req_ready=1 and done=0. Any operation in progress is abandoned before the memory is changed.
- R2: A read (req_op=0) shifts 8 bits while mem_ce is high: the 7 address bits least significant first, then a control bit of 0. The memory takes each bit on a falling edge of mem_clk.
- R3: An erase (req_op=1) shifts the 7 address bits and then a 1, 8 bits in all. A write (req_op=2) and an erase-then-write (req_op=3) shift 16 bits: the data byte least significant first, then the address least significant first, then a 1.
- R4: For an erase the data line is driven to 1, and for a write to 0. The level is driven before mem_ce falls and held without change until after the falling edge of the start pulse.
- R5: Every erase or write cycle has exactly one start pulse. At least T_PROG cycles pass between its falling edge and the rise of mem_ce.
- R6: In a read, 8 clock pulses follow the fall of mem_ce. The bit sensed T_DD cycles after the falling edge of pulse k becomes bit k-1 of rd_data, counting from 1.
- R7: An erase-then-write uses one frame and two low periods of mem_ce: the first erases (line high) and the second writes (line low). No frame bit is shifted between them.
- R8: mem_clk stays high for at least T_HIGH cycles and low for at least T_LOW cycles. At least T_CE cycles separate any edge of mem_ce from any edge of mem_clk.
- R9: mem_d_oe stays low for the whole period in which mem_ce is low during a read.
- R10: req_ready is high only when the controller is idle. A req_valid seen while busy is ignored.
- R11: done is high for exactly one cycle per request: the cycle in which mem_ce rises at the end of the operation. The intermediate rise of an erase-then-write gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 erase, 2 write, 3 erase-then-write |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Value to write |
| req_ready | output | 1 | Idle, request accepted this cycle |
| done | output | 1 | One-cycle end-of-operation strobe |
| rd_data | output | DATA_W | Word from the last read |
| mem_ce | output | 1 | Chip enable to the memory |
| mem_clk | output | 1 | Shift clock / start pulse |
| mem_d_out | output | 1 | Value driven on the data line |
| mem_d_oe | output | 1 | Data line drive enable |
| mem_d_in | input | 1 | Sensed data line |

## Verification
The bench builds the controller with a clock high time of 2, a low time of 3, an edge spacing of 3, a hold of 2, a read delay of 2 and a programming time of 20 cycles. With these values a full 16-bit frame and a programming wait take about a hundred and fifty cycles. That makes it possible to run many erase, write and erase-then-write sequences on a behavioural memory model within the run. The small values also give the model's edge-spacing and pulse-width monitors cycle-exact limits to test against. A short programming time also makes an abort by reset during a frame reachable. A stray request while the controller is busy is reachable in the same way.

// File: rtl/tw_pkg.sv
// Shared types for the three-wire serial EEPROM host controller.
// Assumes: request op codes are fixed by the request port contract.
package tw_pkg;

    typedef enum logic [1:0] {
        OP_READ        = 2'd0,
        OP_ERASE       = 2'd1,
        OP_WRITE       = 2'd2,
        OP_ERASE_WRITE = 2'd3
    } tw_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BIT_SET,
        S_BIT_HI,
        S_BIT_HOLD,
        S_LVL,
        S_CE_LO,
        S_RD_HI,
        S_RD_DLY,
        S_RD_LO,
        S_ST_HI,
        S_ST_HOLD,
        S_PROG,
        S_RAISE,
        S_RECOVER
    } tw_state_e;

endpackage

// File: rtl/tw_interval_timer.sv
// Down counter that times every phase of the line sequencer.
// Assumes: load_val is (phase length - 1); last is high in the final cycle of a phase.
module tw_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/tw_serial_path.sv
// Frame shift register (least significant bit leaves first) with remaining-bit
// count, and receive register that assembles read bits least significant first.
// Assumes: shift is only pulsed while bits remain.
module tw_serial_path #(
    parameter int FRAME_W = 16,
    parameter int RX_W    = 8,
    parameter int LEN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [LEN_W-1:0]   load_len,
    input  logic               shift,
    input  logic               sample,
    input  logic               rx_bit,
    output logic               tx_bit,
    output logic               last_bit,
    output logic [RX_W-1:0]    rx_word
);

    logic [FRAME_W-1:0] tx_sr_q;
    logic [LEN_W-1:0]   rem_q;
    logic [RX_W-1:0]    rx_q;

    // Transmit: load a new frame or move the next bit to position zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            tx_sr_q <= load_frame;
            rem_q   <= load_len;
        end else if (shift) begin
            tx_sr_q <= tx_sr_q >> 1;
            rem_q   <= rem_q - 1'b1;
        end
    end

    // Receive: each sampled bit enters at the top, so the first ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_bit, rx_q[RX_W-1:1]};
        end
    end

    assign tx_bit   = tx_sr_q[0];
    assign last_bit = (rem_q == LEN_W'(1));
    assign rx_word  = rx_q;

    // R2: a bit is never shifted past the end of the loaded frame.
    p_shift_with_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (rem_q != '0));

    // R3: a requested frame length never exceeds the register.
    p_len_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len <= LEN_W'(FRAME_W)));

endmodule

// File: rtl/tw_eeprom_host.sv
// Host master for a 128x8 three-wire serial EEPROM. Serialises a request into
// a frame while chip enable is high, then lowers chip enable and either clocks
// a word out (read) or gives the level-coded start pulse and waits out
// programming (erase/write). Erase-then-write reuses the latched frame.
// Assumes: every T_* parameter is at least 1 and T_LOW exceeds T_DD.
module tw_eeprom_host
    import tw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int T_HIGH = 313,
    parameter int T_LOW  = 625,
    parameter int T_CE   = 625,
    parameter int T_HOLD = 313,
    parameter int T_DD   = 313,
    parameter int T_PROG = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce,
    output logic              mem_clk,
    output logic              mem_d_out,
    output logic              mem_d_oe,
    input  logic              mem_d_in
);

    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int SHORT_W = ADDR_W + 1;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int RD_W    = $clog2(DATA_W + 1);
    localparam int T_M1    = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
    localparam int T_M2    = (T_CE > T_HOLD) ? T_CE : T_HOLD;
    localparam int T_M3    = (T_DD > T_PROG) ? T_DD : T_PROG;
    localparam int T_M12   = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX   = (T_M12 > T_M3) ? T_M12 : T_M3;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    tw_state_e         state_q, state_d;
    tw_op_e            op_q;
    logic              second_q;
    logic [RD_W-1:0]   rd_cnt_q;

    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val;
    logic              path_load, path_shift, path_sample;
    logic              path_tx, path_last;
    logic [FRAME_W-1:0] frame_d;
    logic [LEN_W-1:0]  len_d;

    logic is_read, lvl, mid_ew;
    assign is_read = (op_q == OP_READ);
    assign mid_ew  = (op_q == OP_ERASE_WRITE) && !second_q;
    assign lvl     = (op_q == OP_ERASE) || mid_ew;

    // Build the frame for the incoming request: short frames carry no data.
    always_comb begin
        if (tw_op_e'(req_op) == OP_READ || tw_op_e'(req_op) == OP_ERASE) begin
            frame_d = {{DATA_W{1'b0}}, (tw_op_e'(req_op) == OP_ERASE), req_addr};
            len_d   = LEN_W'(SHORT_W);
        end else begin
            frame_d = {1'b1, req_addr, req_wdata};
            len_d   = LEN_W'(FRAME_W);
        end
    end

    // Sequencer next state and the strobes to the serial path.
    always_comb begin
        state_d     = state_q;
        path_load   = 1'b0;
        path_shift  = 1'b0;
        path_sample = 1'b0;
        case (state_q)
            S_IDLE:     if (req_valid) begin
                            state_d   = S_BIT_SET;
                            path_load = 1'b1;
                        end
            S_BIT_SET:  if (tmr_last) state_d = S_BIT_HI;
            S_BIT_HI:   if (tmr_last) state_d = S_BIT_HOLD;
            S_BIT_HOLD: if (tmr_last) begin
                            path_shift = 1'b1;
                            state_d    = path_last ? S_LVL : S_BIT_SET;
                        end
            S_LVL:      if (tmr_last) state_d = S_CE_LO;
            S_CE_LO:    if (tmr_last) state_d = is_read ? S_RD_HI : S_ST_HI;
            S_RD_HI:    if (tmr_last) state_d = S_RD_DLY;
            S_RD_DLY:   if (tmr_last) begin
                            path_sample = 1'b1;
                            state_d     = S_RD_LO;
                        end
            S_RD_LO:    if (tmr_last)
                            state_d = (rd_cnt_q == RD_W'(DATA_W)) ? S_RAISE : S_RD_HI;
            S_ST_HI:    if (tmr_last) state_d = S_ST_HOLD;
            S_ST_HOLD:  if (tmr_last) state_d = S_PROG;
            S_PROG:     if (tmr_last) state_d = S_RAISE;
            S_RAISE:    state_d = mid_ew ? S_LVL : S_RECOVER;
            S_RECOVER:  if (tmr_last) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Phase length loaded into the timer on entry to each state.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_BIT_SET, S_RD_LO:               tmr_val = CNT_W'(T_LOW - 1);
            S_BIT_HI, S_RD_HI, S_ST_HI:       tmr_val = CNT_W'(T_HIGH - 1);
            S_BIT_HOLD, S_ST_HOLD:            tmr_val = CNT_W'(T_HOLD - 1);
            S_LVL, S_CE_LO, S_RECOVER:        tmr_val = CNT_W'(T_CE - 1);
            S_RD_DLY:                         tmr_val = CNT_W'(T_DD - 1);
            S_PROG:                           tmr_val = CNT_W'(T_PROG - 1);
            default:                          tmr_val = '0;
        endcase
    end

    // Sequencer registers: state, latched op, erase-then-write phase, read bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_READ;
            second_q <= 1'b0;
            rd_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (path_load) begin
                op_q     <= tw_op_e'(req_op);
                second_q <= 1'b0;
                rd_cnt_q <= '0;
            end else begin
                if (state_q == S_RAISE && mid_ew) second_q <= 1'b1;
                if (path_sample) rd_cnt_q <= rd_cnt_q + 1'b1;
            end
        end
    end

    // Line levels decoded from the current phase.
    always_comb begin
        mem_ce    = 1'b1;
        mem_clk   = 1'b0;
        mem_d_out = lvl;
        mem_d_oe  = 1'b0;
        case (state_q)
            S_BIT_SET, S_BIT_HOLD: begin mem_d_out = path_tx; mem_d_oe = 1'b1; end
            S_BIT_HI:  begin mem_d_out = path_tx; mem_d_oe = 1'b1; mem_clk = 1'b1; end
            S_LVL:     mem_d_oe = !is_read;
            S_CE_LO:   begin mem_ce = 1'b0; mem_d_oe = !is_read; end
            S_RD_HI:   begin mem_ce = 1'b0; mem_clk = 1'b1; end
            S_RD_DLY, S_RD_LO, S_PROG: mem_ce = 1'b0;
            S_ST_HI:   begin mem_ce = 1'b0; mem_clk = 1'b1; mem_d_oe = 1'b1; end
            S_ST_HOLD: begin mem_ce = 1'b0; mem_d_oe = 1'b1; end
            default:   ;
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign done      = (state_q == S_RAISE) && !mid_ew;

    tw_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    tw_serial_path #(.FRAME_W(FRAME_W), .RX_W(DATA_W), .LEN_W(LEN_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (path_load),
        .load_frame (frame_d),
        .load_len   (len_d),
        .shift      (path_shift),
        .sample     (path_sample),
        .rx_bit     (mem_d_in),
        .tx_bit     (path_tx),
        .last_bit   (path_last),
        .rx_word    (rd_data)
    );

    // R11: the end strobe lasts one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the end strobe coincides with the rise of chip enable.
    p_done_at_ce_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce && !$past(mem_ce)));

    // R9: the line is released while a read holds chip enable low.
    p_read_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce && op_q == OP_READ) |-> !mem_d_oe);

    // R4: a driven level under low chip enable does not change.
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce && mem_d_oe && $past(!mem_ce && mem_d_oe)) |-> $stable(mem_d_out));

    // R8: chip enable and the clock never switch in the same cycle.
    p_ce_clk_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_ce) |-> $stable(mem_clk));

    // R10: while ready the memory sees an idle bus.
    p_ready_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce && !mem_clk && !mem_d_oe));

endmodule

// File: tb/tw_eeprom_host_test.sv
// Self-checking bench: behavioural three-wire memory model, a vector table of
// requests, then directed tests for reset, abort and a request while busy.
module tw_eeprom_host_test;

    localparam int T_HIGH = 2;
    localparam int T_LOW  = 3;
    localparam int T_CE   = 3;
    localparam int T_HOLD = 2;
    localparam int T_DD   = 2;
    localparam int T_PROG = 20;
    localparam int WD_LIMIT = 150000;
    localparam int NVEC = 14;

    // {op[1:0], addr[6:0], data[7:0]}; op 0 read, 1 erase, 2 write, 3 erase-then-write
    localparam logic [16:0] VEC [NVEC] = '{
        {2'd1, 7'd5,   8'h00}, {2'd2, 7'd5,   8'hA5}, {2'd0, 7'd5,   8'h00},
        {2'd3, 7'd127, 8'h5A}, {2'd0, 7'd127, 8'h00}, {2'd0, 7'd0,   8'h00},
        {2'd2, 7'd0,   8'h0F}, {2'd0, 7'd0,   8'h00}, {2'd1, 7'd64,  8'h00},
        {2'd0, 7'd64,  8'h00}, {2'd3, 7'd1,   8'h00}, {2'd0, 7'd1,   8'h00},
        {2'd3, 7'd126, 8'hFF}, {2'd0, 7'd126, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [6:0] req_addr = 7'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       req_ready, done, mem_ce, mem_clk, mem_d_out, mem_d_oe;
    logic [7:0] rd_data;
    logic       mem_d_in;

    always #4 clk = ~clk;

    tw_eeprom_host #(
        .T_HIGH(T_HIGH), .T_LOW(T_LOW), .T_CE(T_CE),
        .T_HOLD(T_HOLD), .T_DD(T_DD), .T_PROG(T_PROG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .mem_ce(mem_ce), .mem_clk(mem_clk),
        .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe), .mem_d_in(mem_d_in)
    );

    // ---------------- memory model (samples at the falling system clock edge)
    logic [7:0]  m_mem [128];
    logic [15:0] m_sr = '0;
    logic [7:0]  m_out = '0;
    logic [6:0]  m_addr = '0;
    logic        m_inited = 1'b0, m_read = 1'b0, m_prog = 1'b0, m_lvl = 1'b0;
    logic        m_fall_seen = 1'b0, prev_ce = 1'b1, prev_clk = 1'b0, d_line;
    int          m_bits = 0, m_pulse = 0, cyc = 0, fall_cyc = 0;
    int          last_ce_cyc = -1000, last_clk_cyc = -1000;
    int          fall_cnt = 0, done_rise = 0;
    int          v_r4 = 0, v_r5 = 0, v_r8 = 0, v_r9 = 0;
    int          rec_bits [64];
    logic [15:0] rec_sr [64];
    logic        rec_lvl [64];
    logic        m_d_drv = 1'b1;

    assign mem_d_in = m_d_drv;

    always @(negedge clk) begin
        cyc = cyc + 1;
        d_line = mem_d_oe ? mem_d_out : 1'b1;
        if (!rst_n) begin
            if (!m_inited) begin
                for (int i = 0; i < 128; i++) m_mem[i] = 8'((i * 29 + 7) % 256);
                m_inited = 1'b1;
            end
            m_bits = 0; m_read = 1'b0; m_prog = 1'b0; m_d_drv = 1'b1;
            prev_ce = 1'b1; prev_clk = 1'b0;
            last_ce_cyc = -1000; last_clk_cyc = -1000;
        end else begin
            if (mem_clk != prev_clk) begin
                if (cyc - last_ce_cyc < T_CE) v_r8++;
                if (mem_clk && (cyc - last_clk_cyc < T_LOW)) v_r8++;
                if (!mem_clk && (cyc - last_clk_cyc < T_HIGH)) v_r8++;
                last_clk_cyc = cyc;
            end
            if (mem_ce != prev_ce) begin
                if (cyc - last_clk_cyc < T_CE) v_r8++;
                last_ce_cyc = cyc;
            end
            if (mem_ce && !prev_ce) begin
                if (done) done_rise++;
                if (m_prog) begin
                    if (!m_fall_seen || (cyc - fall_cyc < T_PROG)) v_r5++;
                    if (m_lvl) m_mem[m_addr] = 8'hFF;
                    else       m_mem[m_addr] = m_mem[m_addr] & m_sr[7:0];
                end
                m_read = 1'b0; m_prog = 1'b0; m_bits = 0; m_d_drv = 1'b1;
            end else if (!mem_ce && prev_ce) begin
                if (fall_cnt < 64) begin
                    rec_bits[fall_cnt] = m_bits;
                    rec_sr[fall_cnt]   = m_sr;
                    rec_lvl[fall_cnt]  = d_line;
                end
                fall_cnt++;
                m_addr = m_sr[14:8];
                if (m_sr[15]) begin
                    m_prog = 1'b1; m_lvl = d_line; m_fall_seen = 1'b0;
                end else begin
                    m_read = 1'b1; m_pulse = 0;
                end
            end else if (mem_ce) begin
                if (prev_clk && !mem_clk) begin
                    m_sr = {d_line, m_sr[15:1]};
                    m_bits++;
                end
            end else begin
                if (m_prog && !m_fall_seen && d_line != m_lvl) v_r4++;
                if (m_read && mem_d_oe) v_r9++;
                if (mem_clk && !prev_clk) begin
                    if (m_read && m_pulse == 0) m_out = m_mem[m_addr];
                    if (m_prog && m_fall_seen) v_r5++;
                end
                if (!mem_clk && prev_clk) begin
                    if (m_read && m_pulse < 8) begin
                        m_d_drv = m_out[m_pulse];
                        m_pulse++;
                    end
                    if (m_prog) begin
                        fall_cyc = cyc; m_fall_seen = 1'b1;
                    end
                end
            end
            prev_ce = mem_ce; prev_clk = mem_clk;
        end
    end

    // ---------------- bench bookkeeping
    int         n_checks = 0, n_fail = 0;
    logic       wd_hit = 1'b0;
    logic [7:0] sh_mem [128];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_wd();
        @(negedge clk);
        if (cyc > WD_LIMIT) wd_hit = 1'b1;
    endtask

    // Issue one request, wait for its end, and check frame, levels, strobe and data.
    task automatic run_op(input logic [1:0] op, input logic [6:0] addr,
                          input logic [7:0] data, input logic intrude);
        int f0, d0, dones, n;
        logic [7:0] got;
        logic [15:0] exp_sr;
        int exp_bits;
        if (wd_hit) return;
        f0 = fall_cnt; d0 = done_rise; dones = 0; n = 0; got = '0;
        while (!req_ready && !wd_hit) tick_wd();
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = data;
        tick_wd();
        req_valid = 1'b0;
        while (!wd_hit) begin
            if (done) begin dones++; got = rd_data; end
            if (dones > 0 && req_ready) break;
            if (intrude && n == 10) begin
                check(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
                req_valid = 1'b1; req_op = 2'd2; req_wdata = 8'h00;
            end
            if (intrude && n == 11) req_valid = 1'b0;
            n++;
            tick_wd();
        end
        if (wd_hit) return;
        check(dones == 1, "R11 one done strobe", dones, 1);
        check(done_rise - d0 == 1, "R11 done with final ce rise", done_rise - d0, 1);
        check(fall_cnt - f0 == ((op == 2'd3) ? 2 : 1), "R7/R10 ce low periods",
              fall_cnt - f0, (op == 2'd3) ? 2 : 1);
        exp_bits = (op[1]) ? 16 : 8;
        exp_sr   = {(op != 2'd0), addr, data};
        check(rec_bits[f0] == exp_bits, (op[1]) ? "R3 long frame length" : "R2/R3 short frame length",
              rec_bits[f0], exp_bits);
        check(rec_sr[f0][15:8] == exp_sr[15:8], "R2/R3 control and address bits",
              int'(rec_sr[f0][15:8]), int'(exp_sr[15:8]));
        if (op[1])
            check(rec_sr[f0][7:0] == data, "R3 data bits", int'(rec_sr[f0][7:0]), int'(data));
        if (op != 2'd0)
            check(rec_lvl[f0] == (op != 2'd2), "R4 level at ce fall",
                  int'(rec_lvl[f0]), int'(op != 2'd2));
        if (op == 2'd3) begin
            check(rec_bits[f0 + 1] == 0, "R7 no second frame", rec_bits[f0 + 1], 0);
            check(rec_lvl[f0 + 1] == 1'b0, "R7 write level on second ce low",
                  int'(rec_lvl[f0 + 1]), 0);
        end
        case (op)
            2'd0: check(got == sh_mem[addr], "R6 read data", int'(got), int'(sh_mem[addr]));
            2'd1: sh_mem[addr] = 8'hFF;
            2'd2: sh_mem[addr] = sh_mem[addr] & data;
            default: sh_mem[addr] = data;
        endcase
    endtask

    initial begin
        for (int i = 0; i < 128; i++) sh_mem[i] = 8'((i * 29 + 7) % 256);
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check(mem_ce == 1'b1 && mem_clk == 1'b0 && mem_d_oe == 1'b0,
              "R1 bus idle in reset", {mem_ce, mem_clk, mem_d_oe}, 3'b100);
        check(req_ready == 1'b1 && done == 1'b0, "R1 ready, no done in reset",
              {req_ready, done}, 2'b10);
        rst_n = 1'b1;
        tick_wd();

        // Vector table
        for (int k = 0; k < NVEC; k++)
            run_op(VEC[k][16:15], VEC[k][14:8], VEC[k][7:0], 1'b0);

        // R10: stray write request during a read has no effect
        run_op(2'd0, 7'd5, 8'h00, 1'b1);
        run_op(2'd0, 7'd5, 8'h00, 1'b0);

        // R1: reset in the middle of a write frame aborts it
        if (!wd_hit) begin
            req_valid = 1'b1; req_op = 2'd2; req_addr = 7'd5; req_wdata = 8'h00;
            tick_wd();
            req_valid = 1'b0;
            repeat (20) tick_wd();
            rst_n = 1'b0;
            repeat (2) tick_wd();
            check(mem_ce && !mem_clk && !mem_d_oe && req_ready && !done,
                  "R1 abort returns to idle", {mem_ce, mem_clk, mem_d_oe, req_ready, done},
                  5'b10010);
            rst_n = 1'b1;
            tick_wd();
            run_op(2'd0, 7'd5, 8'h00, 1'b0);
        end

        // Monitor totals
        check(v_r4 == 0, "R4 level held through start pulse", v_r4, 0);
        check(v_r5 == 0, "R5 programming interval and single start pulse", v_r5, 0);
        check(v_r8 == 0, "R8 pulse widths and edge spacing", v_r8, 0);
        check(v_r9 == 0, "R9 line released in read", v_r9, 0);
        check(!wd_hit, "watchdog", cyc, WD_LIMIT);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule